// File: doc/BRIEF.md
# Single-Cycle 32-bit Load-Store Processor Core

This block is a compact processor core that completes one fixed-length 32-bit instruction per clock. In each cycle it presents the program counter on an instruction port, decodes the word that comes back and reads two operands from a 32-entry register bank. It then computes a result or a memory address. In the same cycle it drives the data port, and at the next rising edge it writes the destination register and the new program counter.

The instruction port and the data port read without latency: the surrounding logic must return the addressed word in the same cycle. Stores and byte stores drive a write strobe with four byte enables, and the memory captures them at the rising edge. Byte lanes are big-endian. The core handles arithmetic, logic, compare, upper-immediate, word and byte memory access, conditional branches, absolute jumps, call-with-link and jump-through-register. Any other encoding has no effect other than moving on to the next instruction.

Top module: `sc32_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0, so `imem_addr` reads 0 after that edge. No register or memory write takes place while `rst` is high.
- R2: Any instruction that is not a taken branch or a jump sets the next `imem_addr` to the current one plus 4.
- R3: Opcode 0 with funct 32 writes rs+rt to rd, and with funct 34 writes rs−rt to rd. Both wrap modulo 2^32. Opcode 8 writes rs plus the sign-extended 16-bit immediate (bits 15:0) to rt.
- R4: Opcode 13 writes rs OR the zero-extended immediate to rt. Opcode 15 writes the immediate into bits 31:16 of rt and zeros into bits 15:0.
- R5: Opcode 0 with funct 42 writes 1 to rd when rs < rt as signed two's-complement values, and 0 otherwise. Opcode 10 does the same comparison against the sign-extended immediate and writes the result to rt.
- R6: Register 0 always reads as zero, and a write aimed at it is discarded.
- R7: Opcode 35 loads the word at rs + sign-extended offset into rt. Opcode 43 stores rt to that address with all four byte enables set.
- R8: Byte lanes are big-endian. Byte offset k (address bits 1:0) sits in data bits 31−8k down to 24−8k, and its enable is `dmem_be[3−k]`. Opcode 32 loads that byte sign-extended into rt. Opcode 40 asserts only that one enable and puts the low byte of rt on every lane of `dmem_wdata`.
- R9: Opcode 4 (branch when rs equals rt) and opcode 5 (branch when they differ) go to PC+4+(sign-extended immediate × 4) when taken, and to PC+4 when not taken.
- R10: Opcode 2 goes to {bits 31:28 of PC+4, the 26-bit field in bits 25:0, 2'b00}.
- R11: Opcode 3 jumps in the same way as opcode 2 and writes PC+4 to register 31. Opcode 0 with funct 8 goes to the address held in rs.
- R12: Any other opcode, or opcode 0 with any other funct, writes no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data, byte replicated on all lanes for byte stores |
| dmem_be | output | 4 | Byte enables, bit 3 = lowest byte address |
| dmem_we | output | 1 | Store strobe, captured at the rising edge |
| dmem_rdata | input | 32 | Word at the word-aligned `dmem_addr`, same cycle |

## Verification
Two things happen in the same cycle of a call instruction: the link value goes into register 31 and the program counter is redirected. Both must use the PC of the call itself. The bench runs a call to a routine whose only instruction returns through register 31. It follows `imem_addr` edge by edge through the call, the return and the later branches, and it stores register 31 so that the link value can be compared with the call address plus 4. In byte stores, the address adder and the lane steering work on the same low address bits in one cycle. The bench sweeps every byte offset and checks that the neighbouring bytes in memory are left unchanged.

// File: rtl/sc32_pkg.sv
package sc32_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;
  localparam int NREG = 1 << RAW;

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_J    = 6'd2;
  localparam logic [5:0] OP_JAL  = 6'd3;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_BNE  = 6'd5;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_SLTI = 6'd10;
  localparam logic [5:0] OP_ORI  = 6'd13;
  localparam logic [5:0] OP_LUI  = 6'd15;
  localparam logic [5:0] OP_LB   = 6'd32;
  localparam logic [5:0] OP_LW   = 6'd35;
  localparam logic [5:0] OP_SB   = 6'd40;
  localparam logic [5:0] OP_SW   = 6'd43;

  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_OR, ALU_PASSB} alu_op_e;
  typedef enum logic [1:0] {IMM_SEXT, IMM_ZEXT, IMM_UPPER} imm_kind_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_sel_e;

  typedef struct packed {
    logic      reg_we;
    dst_sel_e  dst;
    alu_op_e   alu;
    logic      use_imm;
    imm_kind_e imm_kind;
    logic      mem_rd;
    logic      mem_wr;
    logic      mem_byte;
    logic      br_eq;
    logic      br_ne;
    logic      jump;
    logic      jump_reg;
    logic      link;
  } ctrl_t;
endpackage

// File: rtl/sc32_decode.sv
module sc32_decode
  import sc32_pkg::*;
(
  input  logic [5:0]      op,
  input  logic [5:0]      fn,
  input  logic [15:0]     imm16,
  output ctrl_t           ctrl,
  output logic [XLEN-1:0] imm_ext
);
  always_comb begin
    ctrl          = '0;
    ctrl.dst      = DST_RD;
    ctrl.alu      = ALU_ADD;
    ctrl.imm_kind = IMM_SEXT;
    case (op)
      OP_REG: begin
        case (fn)
          FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_ADD; end
          FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SUB; end
          FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SLT; end
          FN_JR:  ctrl.jump_reg = 1'b1;
          default: ;
        endcase
      end
      OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; end
      OP_SLTI: begin
        ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; ctrl.alu = ALU_SLT;
      end
      OP_ORI: begin
        ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1;
        ctrl.alu = ALU_OR; ctrl.imm_kind = IMM_ZEXT;
      end
      OP_LUI: begin
        ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1;
        ctrl.alu = ALU_PASSB; ctrl.imm_kind = IMM_UPPER;
      end
      OP_LW, OP_LB: begin
        ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1;
        ctrl.mem_rd = 1'b1; ctrl.mem_byte = (op == OP_LB);
      end
      OP_SW, OP_SB: begin
        ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; ctrl.mem_byte = (op == OP_SB);
      end
      OP_BEQ: ctrl.br_eq = 1'b1;
      OP_BNE: ctrl.br_ne = 1'b1;
      OP_J:   ctrl.jump = 1'b1;
      OP_JAL: begin
        ctrl.jump = 1'b1; ctrl.link = 1'b1; ctrl.reg_we = 1'b1; ctrl.dst = DST_LINK;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (ctrl.imm_kind)
      IMM_ZEXT:  imm_ext = {{(XLEN-16){1'b0}}, imm16};
      IMM_UPPER: imm_ext = {imm16, {(XLEN-16){1'b0}}};
      default:   imm_ext = {{(XLEN-16){imm16[15]}}, imm16};
    endcase
  end
endmodule

// File: rtl/sc32_alu.sv
module sc32_alu
  import sc32_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic lt;
  assign lt = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      ALU_SUB:   y = a - b;
      ALU_SLT:   y = {{(W-1){1'b0}}, lt};
      ALU_OR:    y = a | b;
      ALU_PASSB: y = b;
      default:   y = a + b;
    endcase
  end
endmodule

// File: rtl/sc32_regbank.sv
module sc32_regbank #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) mem[wa] <= wd;
  end

  assign rd_a = (ra_a == '0) ? '0 : mem[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : mem[ra_b];
endmodule

// File: rtl/sc32_core.sv
module sc32_core
  import sc32_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic [3:0]      dmem_be,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam logic [RAW-1:0] LINK_REG = RAW'(NREG - 1);

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_target, j_target;
  logic [RAW-1:0]  rs, rt, rd, rf_wa;
  ctrl_t           ctrl;
  logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, ld_val, wb_data;
  logic [7:0]      ld_byte;
  logic [1:0]      lane;
  logic            rf_we, taken;

  assign rs = imem_data[25:21];
  assign rt = imem_data[20:16];
  assign rd = imem_data[15:11];

  sc32_decode u_dec (
    .op      (imem_data[31:26]),
    .fn      (imem_data[5:0]),
    .imm16   (imem_data[15:0]),
    .ctrl    (ctrl),
    .imm_ext (imm_ext)
  );

  sc32_regbank #(.W(XLEN), .AW(RAW)) u_rf (
    .clk  (clk),
    .we   (rf_we),
    .wa   (rf_wa),
    .wd   (wb_data),
    .ra_a (rs),
    .rd_a (rs_val),
    .ra_b (rt),
    .rd_b (rt_val)
  );

  assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

  sc32_alu #(.W(XLEN)) u_alu (
    .op (ctrl.alu),
    .a  (rs_val),
    .b  (alu_b),
    .y  (alu_y)
  );

  // Big-endian lane steering for byte access
  assign lane = alu_y[1:0];
  always_comb begin
    case (lane)
      2'd0:    ld_byte = dmem_rdata[31:24];
      2'd1:    ld_byte = dmem_rdata[23:16];
      2'd2:    ld_byte = dmem_rdata[15:8];
      default: ld_byte = dmem_rdata[7:0];
    endcase
  end
  assign ld_val = ctrl.mem_byte ? {{(XLEN-8){ld_byte[7]}}, ld_byte} : dmem_rdata;

  always_comb begin
    case (ctrl.dst)
      DST_RT:   rf_wa = rt;
      DST_LINK: rf_wa = LINK_REG;
      default:  rf_wa = rd;
    endcase
  end

  assign wb_data = ctrl.link ? pc_plus4 : (ctrl.mem_rd ? ld_val : alu_y);
  assign rf_we   = ctrl.reg_we & ~rst;

  assign dmem_addr  = alu_y;
  assign dmem_we    = ctrl.mem_wr & ~rst;
  assign dmem_be    = ctrl.mem_byte ? (4'b1000 >> lane) : 4'b1111;
  assign dmem_wdata = ctrl.mem_byte ? {4{rt_val[7:0]}} : rt_val;

  // Next-PC selection
  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign j_target  = {pc_plus4[XLEN-1:XLEN-4], imem_data[25:0], 2'b00};
  assign taken     = (ctrl.br_eq && (rs_val == rt_val)) || (ctrl.br_ne && (rs_val != rt_val));

  always_comb begin
    if (ctrl.jump_reg)  pc_next = rs_val;
    else if (ctrl.jump) pc_next = j_target;
    else if (taken)     pc_next = br_target;
    else                pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign imem_addr = pc_q;

  // R2: straight-line flow advances by one word
  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !ctrl.jump_reg && !taken) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  // R9: taken branch lands at word offset from the following instruction
  p_branch_target_r9: assert property (@(posedge clk) disable iff (rst)
    (taken && !ctrl.jump && !ctrl.jump_reg) |=>
      (pc_q == $past(pc_q) + XLEN'(4) + {$past(imm_ext[XLEN-3:0]), 2'b00}));

  // R7 / R8: a store enables all lanes or exactly one
  p_store_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (ctrl.mem_byte ? ($countones(dmem_be) == 1) : (dmem_be == 4'hF)));

  // R11: the link register holds the return address after a call
  p_link_value_r11: assert property (@(posedge clk) disable iff (rst)
    ctrl.link |=> (u_rf.mem[LINK_REG] == $past(pc_q) + XLEN'(4)));

  // R3: a register write lands in the addressed entry
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (rf_we && (rf_wa != '0)) |=> (u_rf.mem[$past(rf_wa)] == $past(wb_data)));
endmodule

// File: tb/sc32_core_bench.sv
module sc32_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic [3:0]  dmem_be;
  logic        dmem_we;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc32_core u_sc32_core (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_be    (dmem_be),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) begin
    if (dmem_we)
      for (int k = 0; k < 4; k++)
        if (dmem_be[k]) dmem[dmem_addr[9:2]][8*k +: 8] <= dmem_wdata[8*k +: 8];
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] enc_j(int op, int tgt);
    return {op[5:0], tgt[25:0]};
  endfunction

  localparam logic [31:0] HALT = {6'd4, 5'd0, 5'd0, 16'hFFFF};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mems();
    for (int i = 0; i < 256; i++) begin
      imem[i] = HALT;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic restart();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam int NV = 6;
  logic [31:0] vals [NV];

  initial begin
    vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'h7FFFFFFF;
    vals[3] = 32'h80000000; vals[4] = 32'hFFFFFFFF; vals[5] = 32'h12345678;

    // R1: reset state
    clear_mems();
    @(posedge clk);
    @(negedge clk);
    check("R1 reset pc", imem_addr, 32'h0);

    // Control flow: R9 R10 R11 R2
    clear_mems();
    imem[0]  = enc_i(8, 0, 1, 16'd3);
    imem[1]  = enc_i(8, 0, 2, 16'd3);
    imem[2]  = enc_i(4, 1, 2, 16'd2);
    imem[3]  = enc_i(43, 0, 1, 16'd4);
    imem[4]  = enc_i(43, 0, 1, 16'd4);
    imem[5]  = enc_i(5, 1, 2, 16'd5);
    imem[6]  = enc_j(3, 16);
    imem[16] = enc_r(31, 0, 0, 8);
    imem[7]  = enc_j(2, 40);
    imem[40] = enc_i(5, 1, 0, 16'hFFFD);
    imem[38] = enc_i(43, 0, 31, 16'd0);
    imem[39] = HALT;
    restart();
    check("R1 pc after release", imem_addr, 32'd0);
    @(negedge clk); check("R2 addi advance", imem_addr, 32'd4);
    @(negedge clk); check("R2 addi advance", imem_addr, 32'd8);
    @(negedge clk); check("R9 beq taken", imem_addr, 32'd20);
    @(negedge clk); check("R9 bne not taken", imem_addr, 32'd24);
    @(negedge clk); check("R11 jal target", imem_addr, 32'd64);
    @(negedge clk); check("R11 jr return", imem_addr, 32'd28);
    @(negedge clk); check("R10 j target", imem_addr, 32'd160);
    @(negedge clk); check("R9 bne taken backward", imem_addr, 32'd152);
    @(negedge clk); check("R2 sw advance", imem_addr, 32'd156);
    @(negedge clk); check("R9 self branch", imem_addr, 32'd156);
    check("R11 link value", dmem[0], 32'd28);
    check("R9 skipped store", dmem[1], 32'd0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid run", imem_addr, 32'd0);

    // Arithmetic sweep: R3 R4 R5
    for (int ia = 0; ia < NV; ia++) begin
      for (int ib = 0; ib < NV; ib++) begin
        logic [31:0] a, b;
        a = vals[ia];
        b = vals[ib];
        clear_mems();
        imem[0]  = enc_i(15, 0, 1, a[31:16]);
        imem[1]  = enc_i(13, 1, 1, a[15:0]);
        imem[2]  = enc_i(15, 0, 2, b[31:16]);
        imem[3]  = enc_i(13, 2, 2, b[15:0]);
        imem[4]  = enc_r(1, 2, 3, 32);
        imem[5]  = enc_r(1, 2, 4, 34);
        imem[6]  = enc_r(1, 2, 5, 42);
        imem[7]  = enc_i(8, 1, 6, 16'hFFF0);
        imem[8]  = enc_i(10, 1, 7, 16'hFFFF);
        imem[9]  = enc_i(13, 1, 8, 16'h8001);
        imem[10] = enc_i(15, 0, 9, 16'h8001);
        for (int s = 0; s < 7; s++) imem[11+s] = enc_i(43, 0, 3+s, 16'(4*s));
        restart();
        repeat (20) @(negedge clk);
        check("R3 add", dmem[0], a + b);
        check("R3 sub", dmem[1], a - b);
        check("R5 slt", dmem[2], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        check("R3 addi", dmem[3], a - 32'd16);
        check("R5 slti", dmem[4], ($signed(a) < -1) ? 32'd1 : 32'd0);
        check("R4 ori", dmem[5], a | 32'h00008001);
        check("R4 lui", dmem[6], 32'h80010000);
      end
    end

    // Byte access sweep: R8
    for (int k = 0; k < 4; k++) begin
      logic [31:0] src, exp_lb, exp_sb, mask;
      src = 32'h807F12F0;
      clear_mems();
      dmem[4]  = src;
      dmem[12] = 32'h11223344;
      imem[0] = enc_i(32, 0, 1, 16'(16 + k));
      imem[1] = enc_i(43, 0, 1, 16'd32);
      imem[2] = enc_i(8, 0, 2, 16'h01AB);
      imem[3] = enc_i(40, 0, 2, 16'(48 + k));
      restart();
      repeat (6) @(negedge clk);
      exp_lb = (src >> (8 * (3 - k))) & 32'hFF;
      if (exp_lb[7]) exp_lb = exp_lb | 32'hFFFFFF00;
      mask   = 32'hFF << (8 * (3 - k));
      exp_sb = (32'h11223344 & ~mask) | (32'hAB << (8 * (3 - k)));
      check("R8 lb lane", dmem[8], exp_lb);
      check("R8 sb lane", dmem[12], exp_sb);
    end

    // Word access, zero register, unknown encodings: R7 R6 R12
    clear_mems();
    dmem[4]  = 32'hCAFE1234;
    dmem[16] = 32'hFFFFFFFF;
    dmem[17] = 32'hFFFFFFFF;
    imem[0]  = enc_i(8, 0, 5, 16'd100);
    imem[1]  = enc_i(35, 5, 6, 16'hFFAC);
    imem[2]  = enc_i(43, 5, 6, 16'hFFD8);
    imem[3]  = enc_i(8, 0, 0, 16'd7);
    imem[4]  = enc_r(0, 0, 7, 32);
    imem[5]  = enc_i(43, 0, 0, 16'd64);
    imem[6]  = enc_i(43, 0, 7, 16'd68);
    imem[7]  = enc_i(8, 0, 1, 16'd5);
    imem[8]  = 32'hFC21FFFF;
    imem[9]  = enc_r(1, 1, 1, 63);
    imem[10] = enc_i(43, 0, 1, 16'd72);
    restart();
    repeat (14) @(negedge clk);
    check("R7 lw/sw negative offset", dmem[15], 32'hCAFE1234);
    check("R6 r0 reads zero", dmem[16], 32'h0);
    check("R6 write to r0 ignored", dmem[17], 32'h0);
    check("R12 unknown encodings inert", dmem[18], 32'd5);
    check("R12 pc reached halt", imem_addr, 32'd44);

    finish_run();
  end
endmodule